// File: doc/BRIEF.md
# Buffer Memory Self-Test Fill Engine

This block exercises a byte-wide buffer memory of 8 Kbytes (addressed 0x0000 to 0x1FFF) on its own. Software programs a control byte and an 8-bit seed through a four-entry register interface and then sets the start bit. The engine writes every buffer location in ascending order. The data comes from one of three generators: a pseudo-random sequence started from the seed, the low byte of each location's own address, or the seed rotated left by a programmable amount after each write.

After the fill, the engine reads the whole buffer back in order. It folds the bytes into a 16-bit ones-complement checksum, which software reads as two byte registers. The start bit doubles as the busy flag and clears itself when the engine finishes.

The buffer has two ports, one for this engine and one for a DMA client. A control bit swaps which physical port each client uses. This lets both memory ports be tested without rewiring.

Top module: `bist_fill_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00 and neither memory port is written.
- R2: Register map by `reg_addr`: 0 = control, 1 = seed, 2 = checksum bits 15:8, 3 = checksum bits 7:0. Control bit 0 = start/busy, bit 1 = enable, bits 3:2 = mode, bit 4 = port swap, bits 7:5 = rotate amount. Writing control with bit 0 = 1, bit 1 = 1 and mode other than 3 starts a test. Bit 0 reads 1 until the test finishes and then clears by itself.
- R3: In the fill phase, addresses 0x0000 to 0x1FFF are each written exactly once, in ascending order, one per cycle.
- R4: Mode 0 (random): location n receives the n-th state of an 8-bit LFSR. The first state is the seed, or 0x01 when the seed is 0x00. Next state = {s[6:0], s[7]^s[5]^s[4]^s[3]}. The state is never zero.
- R5: Mode 1 (address): each location receives the low 8 bits of its address, and the seed has no effect.
- R6: Mode 2 (rotate): location 0 receives the seed. Each following location receives the previous value rotated left by control bits 7:5. The rotate amount has no effect in modes 0 and 1.
- R7: After the fill, every location is read in order. The checksum is the 16-bit ones-complement sum (carry out added back in), starting from 0, of the words {byte[2k], byte[2k+1]}. It is final when busy clears.
- R8: A start with bit 1 clear, or with mode 3, is refused. Busy reads 0 from the next cycle, and no memory write occurs.
- R9: With control bit 4 = 0, the engine uses port A and the DMA inputs drive port B. With bit 4 = 1, the engine uses port B and the DMA inputs drive port A.
- R10: While busy, register writes are ignored: the control and seed values and the running test are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dma_we | input | 1 | DMA client write enable |
| dma_addr | input | 13 | DMA client address |
| dma_wdata | input | 8 | DMA client write data |
| dma_rdata | output | 8 | DMA client read data |
| pa_we | output | 1 | Memory port A write enable |
| pa_addr | output | 13 | Memory port A address |
| pa_wdata | output | 8 | Memory port A write data |
| pa_rdata | input | 8 | Memory port A read data, one cycle after address |
| pb_we | output | 1 | Memory port B write enable |
| pb_addr | output | 13 | Memory port B address |
| pb_wdata | output | 8 | Memory port B write data |
| pb_rdata | input | 8 | Memory port B read data, one cycle after address |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the address is presented. They also assume that the DMA client stays off its port while a test runs, since the engine has no arbitration with it. The bench's memory model is a registered dual-port array with that latency. The bench holds the DMA write enable low and only moves the DMA address, so the swap can be seen without disturbing the stored data. Register writes issued mid-test go through the normal register port, so the lock-out is exercised only through legal strobes.

// File: rtl/bist_pkg.sv
// Shared types for the buffer self-test engine.
// Assumes a byte-wide memory; the mode encoding is fixed by software.
package bist_pkg;
    typedef enum logic [1:0] {
        MODE_RAND  = 2'd0,
        MODE_ADDR  = 2'd1,
        MODE_ROT   = 2'd2,
        MODE_RSVD  = 2'd3
    } fill_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_READ = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_t;

    // Rotate a byte left by a 0..7 amount.
    function automatic logic [7:0] rotl8(input logic [7:0] v, input logic [2:0] n);
        logic [15:0] d;
        d = {v, v} << n;
        return d[15:8];
    endfunction

    // One step of the 8-bit LFSR, taps 8,6,5,4.
    function automatic logic [7:0] lfsr8(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/bist_regs.sv
// Register file: control, seed, checksum readback.
// Assumes the sequencer pulses done or reject for one cycle to clear busy.
module bist_regs
    import bist_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] csum,
    input  logic        clr_busy,
    input  logic        seq_idle,
    output logic [7:0]  ctrl,
    output logic [7:0]  seed,
    output logic        cfg_ok
);
    logic busy;
    assign busy   = ctrl[0];
    assign cfg_ok = ctrl[1] && (ctrl[3:2] != MODE_RSVD);

    // Hold control and seed; writes accepted only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            seed <= '0;
        end else if (busy) begin
            if (clr_busy) ctrl[0] <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == 2'd0) ctrl <= reg_wdata;
            if (reg_addr == 2'd1) seed <= reg_wdata;
        end
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = ctrl;
            2'd1:    reg_rdata = seed;
            2'd2:    reg_rdata = csum[15:8];
            default: reg_rdata = csum[7:0];
        endcase
    end

    // R8
    reject_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_idle && !cfg_ok) |=> !ctrl[0]);
    // R10
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (ctrl[7:1] == $past(ctrl[7:1]) && seed == $past(seed)));
endmodule

// File: rtl/bist_patgen.sv
// Fill data generator for the three modes.
// Assumes load and adv never assert together and mode is stable during a test.
module bist_patgen
    import bist_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       adv,
    input  fill_mode_t mode,
    input  logic [2:0] shamt,
    input  logic [7:0] seed,
    input  logic [7:0] addr_lo,
    output logic [7:0] data
);
    logic [7:0] pat;

    // Load from the seed at start, step once per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat <= '0;
        end else if (load) begin
            pat <= (mode == MODE_RAND && seed == 8'h00) ? 8'h01 : seed;
        end else if (adv) begin
            case (mode)
                MODE_RAND: pat <= lfsr8(pat);
                MODE_ROT:  pat <= rotl8(pat, shamt);
                default:   pat <= pat;
            endcase
        end
    end

    // Address mode bypasses the state register.
    assign data = (mode == MODE_ADDR) ? addr_lo : pat;

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RAND && adv) |-> (data != 8'h00));
    // R6
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ROT && $past(adv) && !$past(load) && !$past(!rst_n))
            |-> (pat == rotl8($past(pat), $past(shamt))));
endmodule

// File: rtl/bist_seq.sv
// Address sequencer: fill pass, read pass, one tail cycle for read latency.
// Assumes memory read data arrives one cycle after the address.
module bist_seq
    import bist_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              cfg_ok,
    output logic              load,
    output logic              we,
    output logic              rd_valid,
    output logic              rd_lsb,
    output logic              clr_busy,
    output logic              idle,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    seq_state_t state;

    assign idle     = (state == ST_IDLE);
    assign load     = idle && busy && cfg_ok;
    assign we       = (state == ST_FILL);
    assign clr_busy = (idle && busy && !cfg_ok) || (state == ST_TAIL);

    // Walk the address space twice, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (load) begin
                    state <= ST_FILL;
                    addr  <= '0;
                end
                ST_FILL: begin
                    addr <= addr + 1'b1;
                    if (addr == LAST) state <= ST_READ;
                end
                ST_READ: begin
                    addr <= addr + 1'b1;
                    if (addr == LAST) state <= ST_TAIL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Mark which cycle carries returned read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_lsb   <= 1'b0;
        end else begin
            rd_valid <= (state == ST_READ);
            rd_lsb   <= addr[0];
        end
    end

    // R3
    fill_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && $past(state) == ST_FILL) |-> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/bist_csum.sv
// Ones-complement checksum of big-endian byte pairs.
// Assumes data arrives in ascending address order starting at an even address.
module bist_csum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        valid,
    input  logic        lsb,
    input  logic [7:0]  data,
    output logic [15:0] sum
);
    logic [7:0]  hi_byte;
    logic [16:0] raw;
    assign raw = {1'b0, sum} + {1'b0, hi_byte, data};

    // Capture the even byte, fold in the pair on the odd byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum     <= '0;
            hi_byte <= '0;
        end else if (valid) begin
            if (!lsb) hi_byte <= data;
            else      sum     <= raw[15:0] + {15'd0, raw[16]};
        end
    end
endmodule

// File: rtl/bist_fill_ctrl.sv
// Top of the buffer self-test engine: registers, sequencer, generator,
// checksum and the port swap between the engine and the DMA client.
// Assumes the DMA client stays idle while a test runs.
module bist_fill_ctrl
    import bist_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [7:0]        dma_wdata,
    output logic [7:0]        dma_rdata,
    output logic              pa_we,
    output logic [ADDR_W-1:0] pa_addr,
    output logic [7:0]        pa_wdata,
    input  logic [7:0]        pa_rdata,
    output logic              pb_we,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [7:0]        pb_wdata,
    input  logic [7:0]        pb_rdata
);
    logic [7:0]        ctrl, seed, fill_data, bist_rdata;
    logic [15:0]       csum;
    logic              cfg_ok, clr_busy, idle, load, we, rd_valid, rd_lsb, swap;
    logic [ADDR_W-1:0] addr;
    fill_mode_t        mode;

    assign mode = fill_mode_t'(ctrl[3:2]);
    assign swap = ctrl[4];

    bist_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .csum(csum),
        .clr_busy(clr_busy), .seq_idle(idle), .ctrl(ctrl), .seed(seed),
        .cfg_ok(cfg_ok)
    );

    bist_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(ctrl[0]), .cfg_ok(cfg_ok), .load(load),
        .we(we), .rd_valid(rd_valid), .rd_lsb(rd_lsb), .clr_busy(clr_busy),
        .idle(idle), .addr(addr)
    );

    bist_patgen u_pat (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(we), .mode(mode),
        .shamt(ctrl[7:5]), .seed(seed), .addr_lo(addr[7:0]), .data(fill_data)
    );

    bist_csum u_csum (
        .clk(clk), .rst_n(rst_n), .clear(load), .valid(rd_valid), .lsb(rd_lsb),
        .data(bist_rdata), .sum(csum)
    );

    // Route engine and DMA client to the two memory ports.
    always_comb begin
        if (swap) begin
            pb_we = we;      pb_addr = addr;     pb_wdata = fill_data;
            pa_we = dma_we;  pa_addr = dma_addr; pa_wdata = dma_wdata;
            bist_rdata = pb_rdata;
            dma_rdata  = pa_rdata;
        end else begin
            pa_we = we;      pa_addr = addr;     pa_wdata = fill_data;
            pb_we = dma_we;  pb_addr = dma_addr; pb_wdata = dma_wdata;
            bist_rdata = pa_rdata;
            dma_rdata  = pb_rdata;
        end
    end

    // R9
    swap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && $past(ctrl[0])) |-> $stable(swap));
endmodule

// File: tb/bist_fill_ctrl_tb_top.sv
`timescale 1ns/1ps
module bist_fill_ctrl_tb_top;
    localparam int AW = 13;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          dma_we = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [7:0]    dma_wdata = '0;
    logic [7:0]    dma_rdata;
    logic          pa_we, pb_we;
    logic [AW-1:0] pa_addr, pb_addr;
    logic [7:0]    pa_wdata, pb_wdata;
    logic [7:0]    pa_rdata = '0, pb_rdata = '0;

    int n_checks = 0, n_fail = 0;
    int wcount = 0;
    int next_wa = 0;
    bit order_err = 0;
    bit finished = 0;
    logic [7:0] mem [N];
    logic [7:0] exp_mem [N];

    always #4 clk = ~clk;

    bist_fill_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_we(dma_we),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_rdata(pa_rdata),
        .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata)
    );

    // Dual-port memory model with one-cycle read latency and a write monitor.
    always @(posedge clk) begin
        if (pa_we) mem[pa_addr] <= pa_wdata;
        if (pb_we) mem[pb_addr] <= pb_wdata;
        pa_rdata <= mem[pa_addr];
        pb_rdata <= mem[pb_addr];
        if (rst_n && (pa_we || pb_we)) begin
            if (int'(pa_we ? pa_addr : pb_addr) != next_wa) order_err = 1;
            next_wa = next_wa + 1;
            wcount  = wcount + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic build_expected(input logic [1:0] mode, input logic [7:0] sd, input int sh);
        logic [7:0] p;
        p = (mode == 2'd0 && sd == 8'h00) ? 8'h01 : sd;
        for (int i = 0; i < N; i++) begin
            if (mode == 2'd1) exp_mem[i] = i[7:0];
            else exp_mem[i] = p;
            if (mode == 2'd0) p = {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
            if (mode == 2'd2) for (int k = 0; k < sh; k++) p = {p[6:0], p[7]};
        end
    endtask

    function automatic logic [15:0] exp_sum();
        int s = 0;
        for (int i = 0; i < N; i += 2) begin
            s = s + {exp_mem[i], exp_mem[i+1]};
            s = (s & 16'hFFFF) + (s >> 16);
        end
        return s[15:0];
    endfunction

    task automatic wait_idle(output bit ok);
        logic [7:0] c;
        ok = 0;
        for (int t = 0; t < 3 * N; t++) begin
            @(negedge clk);
            rd(2'd0, c);
            if (!c[0]) begin ok = 1; break; end
        end
    endtask

    // Runs one full test and compares fill contents, order and checksum.
    task automatic run_test(input string tag, input logic [1:0] mode, input logic [7:0] sd,
                            input logic [2:0] sh, input bit swp, input bit meddle);
        logic [7:0] c, h, l;
        bit ok;
        int bad = -1;
        wcount = 0; next_wa = 0; order_err = 0;
        wr(2'd1, sd);
        wr(2'd0, {sh, swp, mode, 2'b11});
        rd(2'd0, c);
        check(c[0] == 1'b1, {tag, " R2 busy set"}, c, 1);
        if (meddle) begin
            wr(2'd0, 8'h00);
            wr(2'd1, ~sd);
            rd(2'd0, c);
            check(c == {sh, swp, mode, 2'b11}, "R10 ctrl locked", c, {sh, swp, mode, 2'b11});
            rd(2'd1, c);
            check(c == sd, "R10 seed locked", c, sd);
        end
        if (swp) begin
            for (int k = 0; k < 4; k++) @(negedge clk);
            dma_addr = 13'h1ABC;
            #1;
            check(pa_we == 0 && pb_we == 1 && pa_addr == 13'h1ABC, "R9 swapped ports",
                  {pa_we, pb_we}, 2'b01);
        end else if (!meddle) begin
            @(negedge clk);
            dma_addr = 13'h0123;
            #1;
            check(pa_we == 1 && pb_we == 0 && pb_addr == 13'h0123, "R9 normal ports",
                  {pa_we, pb_we}, 2'b10);
        end
        wait_idle(ok);
        check(ok, {tag, " R2 busy self-clears"}, ok, 1);
        check(wcount == N && !order_err, {tag, " R3 each address once ascending"}, wcount, N);
        build_expected(mode, sd, sh);
        for (int i = 0; i < N; i++) if (mem[i] !== exp_mem[i] && bad < 0) bad = i;
        check(bad < 0, {tag, " R4/R5/R6 fill data"}, bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : exp_mem[bad]);
        rd(2'd2, h);
        rd(2'd3, l);
        check({h, l} == exp_sum(), {tag, " R7 checksum"}, {h, l}, exp_sum());
    endtask

    task automatic test_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(v == 8'h00, "R1 register reset value", v, 0);
        end
        check(wcount == 0, "R1 no writes after reset", wcount, 0);
    endtask

    task automatic test_reject(input logic [7:0] cv, input string why);
        logic [7:0] c;
        int w0 = wcount;
        wr(2'd0, cv);
        @(negedge clk);
        rd(2'd0, c);
        check(c[0] == 1'b0, {"R8 refused start ", why}, c[0], 0);
        for (int k = 0; k < 4; k++) @(negedge clk);
        check(wcount == w0, {"R8 no writes ", why}, wcount, w0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_reject(8'b0000_0001, "enable clear");
        test_reject(8'b0000_1111, "mode 3");
        run_test("rand", 2'd0, 8'hA5, 3'd7, 1'b0, 1'b0);
        run_test("rand0", 2'd0, 8'h00, 3'd0, 1'b0, 1'b0);
        run_test("addr", 2'd1, 8'h5A, 3'd5, 1'b0, 1'b1);
        run_test("rot", 2'd2, 8'h81, 3'd3, 1'b0, 1'b0);
        run_test("rotswap", 2'd2, 8'h3C, 3'd1, 1'b1, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule